// File: doc/BRIEF.md
# Serial Port Register and Status Front End

This block is the bus-facing register file of a simple serial port. A host issues one request per cycle (read or write, a byte offset inside a 40-byte window with registers every four bytes, and an 8-bit write value). It answers every request one cycle later with a 16-bit read value and an error flag.

The block stores the mode, bit-rate, control, FIFO-control and port settings. It keeps five status flags and forwards each byte written to the transmit data register onto a one-cycle valid/data stream. A build parameter selects the plain variant or the FIFO variant. The two variants differ in which offsets exist and in which mode and control bits can be written.

A small response state machine tracks each request cycle. `ST_IDLE` is the state when no request was taken on the previous edge. `ST_ACK` follows an accepted request to an implemented offset. `ST_FAULT` follows a request to an offset that the variant does not implement. The next state is chosen only from the request just taken: no request goes to `ST_IDLE`, an implemented offset goes to `ST_ACK`, and any other offset goes to `ST_FAULT`.

Line serialisation, baud generation, receive storage and interrupts belong to neighbouring blocks. Those blocks report receive events and the receive count through dedicated inputs.

Top module: `sercsr_front`

## Requirements
- R1: Every request sampled with `req_valid` high gets `rsp_valid` high in the following cycle. A cycle without a request gives `rsp_valid` low in the following cycle. A write that succeeds returns read data 0.
- R2: An offset that is not a multiple of 4, lies at 0x28 or above, or is not implemented by the variant gives `rsp_err` high with read data 0xFFFF, and the access changes no state. The plain variant implements writes at 0x00, 0x04, 0x08 and 0x0C, and reads at 0x00, 0x04, 0x08 and 0x0C. The FIFO variant implements writes at 0x00–0x10, 0x18, 0x20 and 0x24, and reads at 0x00–0x08, 0x10, 0x18, 0x1C, 0x20 and 0x24. Offset 0x14 exists in neither variant.
- R3: In the FIFO variant, writes are stored masked: the mode register (0x00) with 0x7B and the control register (0x08) with 0xFB. In the plain variant all eight bits are stored. Both registers read back their stored value.
- R4: A control write with bit 5 (transmit enable) equal to 0 sets the transmit-end flag.
- R5: A write to 0x0C stores the byte and clears the transmit-data-empty flag. In the next cycle it raises `tx_valid` for one cycle, with `tx_data` equal to the byte. In the plain variant, a read of 0x0C returns the stored byte.
- R6: A status read (0x10) places transmit end on bit 6, transmit data empty on bit 5, break on bit 4, receive full on bit 1 and data ready on bit 0. Every other bit is 0.
- R7: A status write clears each of those five flags whose bit position is written as 0, and leaves every flag whose bit is written as 1 unchanged.
- R8: A status read returns the flags as they were before the read. If control bit 5 is 1, the read then sets transmit end and transmit data empty. If control bit 5 is 0, the read leaves the flags unchanged.
- R9: After reset, transmit end and transmit data empty are 1 and the other flags are 0. The bit-rate register (0x04) is 0xFF. The mode, control, FIFO-control and port registers are 0. The transmit data register is 0xFF.
- R10: A read of 0x1C returns `rx_count`, zero-extended.
- R11: Offset 0x24 reads as 0, and writes to it are accepted without effect.
- R12: A high `evt_break`, `evt_rx_full` or `evt_rx_ready` sets the break, receive-full or data-ready flag respectively. If the flag is cleared by a status write in the same cycle, the set takes effect.
- R13: The FIFO-control register (0x18) and the port register (0x20) read back the byte last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (6) | Byte offset in the register window |
| req_wdata | input | DATA_W (8) | Write value |
| rx_count | input | CNT_W (5) | Current receive byte count |
| evt_break | input | 1 | Sets the break flag |
| evt_rx_full | input | 1 | Sets the receive-full flag |
| evt_rx_ready | input | 1 | Sets the data-ready flag |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Previous request hit an unimplemented offset |
| rsp_rdata | output | RDATA_W (16) | Read value of the previous request |
| tx_valid | output | 1 | One-cycle pulse: a byte to transmit |
| tx_data | output | DATA_W (8) | Byte to transmit |

## Verification
The assertions assume that the request inputs are stable across each sampling edge and that `req_addr` is fully defined whenever `req_valid` is high. The checks on status and line-status read data also assume the variant parameter is the one the checker is built with. The bench drives every request and event on the falling clock edge and releases it on the next falling edge, so each request occupies exactly one sampling edge. Event pulses are applied either in cycles without a request or together with a single status write, which exercises the set-over-clear priority without overlapping any other access.

// File: rtl/sercsr_pkg.sv
package sercsr_pkg;

    // status bit positions seen by software
    localparam int STAT_TEND_BIT = 6;
    localparam int STAT_TDE_BIT  = 5;
    localparam int STAT_BRK_BIT  = 4;
    localparam int STAT_RXF_BIT  = 1;
    localparam int STAT_RDY_BIT  = 0;
    // transmit enable position in the control register
    localparam int CTRL_TXEN_BIT = 5;

    // register selected by word index (offset / 4)
    typedef enum logic [3:0] {
        REG_MODE  = 4'd0,
        REG_RATE  = 4'd1,
        REG_CTRL  = 4'd2,
        REG_TXD   = 4'd3,
        REG_STAT  = 4'd4,
        REG_GAP   = 4'd5,
        REG_FCTL  = 4'd6,
        REG_RXCNT = 4'd7,
        REG_PORT  = 4'd8,
        REG_LINE  = 4'd9,
        REG_NONE  = 4'd15
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACK   = 2'd1,
        ST_FAULT = 2'd2
    } rsp_state_e;

    typedef struct packed {
        logic tend;
        logic tde;
        logic brk;
        logic rxf;
        logic rdy;
    } flags_t;

endpackage

// File: rtl/sercsr_decode.sv
module sercsr_decode
    import sercsr_pkg::*;
#(
    parameter bit FIFO_VARIANT = 1'b1,
    parameter int ADDR_W       = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    output reg_sel_e          sel,
    output logic              hit
);

    localparam int IDX_W        = ADDR_W - 2;
    localparam int WINDOW_WORDS = 10;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WINDOW_WORDS - 1);

    logic [IDX_W-1:0] idx;
    assign idx = addr[ADDR_W-1:2];

    // R2: unaligned or out-of-window offsets select nothing
    always_comb begin
        sel = REG_NONE;
        if (addr[1:0] == 2'b00 && idx <= LAST_IDX) begin
            sel = reg_sel_e'(idx[3:0]);
        end
    end

    // R2: per-variant, per-direction implementation map
    always_comb begin
        case (sel)
            REG_MODE, REG_RATE, REG_CTRL:          hit = 1'b1;
            REG_TXD:                               hit = is_write || !FIFO_VARIANT;
            REG_STAT, REG_FCTL, REG_PORT, REG_LINE: hit = FIFO_VARIANT;
            REG_RXCNT:                             hit = FIFO_VARIANT && !is_write;
            default:                               hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/sercsr_flags.sv
module sercsr_flags
    import sercsr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   stat_wr,
    input  flags_t keep_mask,
    input  logic   stat_rd,
    input  logic   txd_wr,
    input  logic   ctrl_wr,
    input  logic   ctrl_new_txen,
    input  logic   txen,
    input  logic   evt_break,
    input  logic   evt_rx_full,
    input  logic   evt_rx_ready,
    output flags_t flags
);

    flags_t nxt;

    always_comb begin
        nxt = flags;
        // R4: disabling the transmitter marks transmission ended
        if (ctrl_wr && !ctrl_new_txen) nxt.tend = 1'b1;
        // R5: new transmit byte pending
        if (txd_wr) nxt.tde = 1'b0;
        // R7: clear on written zero
        if (stat_wr) nxt = nxt & keep_mask;
        // R8: instant completion re-arms after a status read
        if (stat_rd && txen) begin
            nxt.tend = 1'b1;
            nxt.tde  = 1'b1;
        end
        // R12: events set last, so they win over a clear
        if (evt_break)    nxt.brk = 1'b1;
        if (evt_rx_full)  nxt.rxf = 1'b1;
        if (evt_rx_ready) nxt.rdy = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= flags_t'(5'b11000);   // R9
        end else begin
            flags <= nxt;
        end
    end

endmodule

// File: rtl/sercsr_regs.sv
module sercsr_regs
    import sercsr_pkg::*;
#(
    parameter bit FIFO_VARIANT = 1'b1,
    parameter int DATA_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] rate_q,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] txd_q,
    output logic [DATA_W-1:0] fctl_q,
    output logic [DATA_W-1:0] port_q,
    output logic              tx_valid
);

    localparam logic [DATA_W-1:0] ALL_ONES  = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] MODE_MASK = FIFO_VARIANT ? DATA_W'(8'h7B) : ALL_ONES;
    localparam logic [DATA_W-1:0] CTRL_MASK = FIFO_VARIANT ? DATA_W'(8'hFB) : ALL_ONES;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            rate_q   <= ALL_ONES;
            ctrl_q   <= '0;
            txd_q    <= ALL_ONES;
            fctl_q   <= '0;
            port_q   <= '0;
            tx_valid <= 1'b0;
        end else begin
            tx_valid <= 1'b0;
            if (wr_en) begin
                case (sel)
                    REG_MODE: mode_q <= wdata & MODE_MASK;   // R3
                    REG_RATE: rate_q <= wdata;
                    REG_CTRL: ctrl_q <= wdata & CTRL_MASK;   // R3
                    REG_TXD: begin                           // R5
                        txd_q    <= wdata;
                        tx_valid <= 1'b1;
                    end
                    REG_FCTL: fctl_q <= wdata;               // R13
                    REG_PORT: port_q <= wdata;               // R13
                    default: ;                               // R11
                endcase
            end
        end
    end

endmodule

// File: rtl/sercsr_front.sv
module sercsr_front
    import sercsr_pkg::*;
#(
    parameter bit FIFO_VARIANT = 1'b1,
    parameter int ADDR_W       = 6,
    parameter int DATA_W       = 8,
    parameter int RDATA_W      = 16,
    parameter int CNT_W        = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic               evt_break,
    input  logic               evt_rx_full,
    input  logic               evt_rx_ready,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [RDATA_W-1:0] rsp_rdata,
    output logic               tx_valid,
    output logic [DATA_W-1:0]  tx_data
);

    reg_sel_e          sel;
    logic              hit;
    logic              wr_go, rd_go;
    flags_t            flags;
    flags_t            keep_mask;
    logic [DATA_W-1:0] mode_q, rate_q, ctrl_q, txd_q, fctl_q, port_q;
    logic [RDATA_W-1:0] stat_word, rd_word, rdata_d;
    rsp_state_e        state_q, state_d;

    function automatic logic [RDATA_W-1:0] zext(input logic [DATA_W-1:0] v);
        return {{(RDATA_W-DATA_W){1'b0}}, v};
    endfunction

    sercsr_decode #(
        .FIFO_VARIANT(FIFO_VARIANT),
        .ADDR_W      (ADDR_W)
    ) u_decode (
        .addr    (req_addr),
        .is_write(req_write),
        .sel     (sel),
        .hit     (hit)
    );

    assign wr_go = req_valid && req_write && hit;
    assign rd_go = req_valid && !req_write && hit;

    assign keep_mask = '{tend: req_wdata[STAT_TEND_BIT], tde: req_wdata[STAT_TDE_BIT],
                         brk:  req_wdata[STAT_BRK_BIT],  rxf: req_wdata[STAT_RXF_BIT],
                         rdy:  req_wdata[STAT_RDY_BIT]};

    sercsr_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .stat_wr      (wr_go && sel == REG_STAT),
        .keep_mask    (keep_mask),
        .stat_rd      (rd_go && sel == REG_STAT),
        .txd_wr       (wr_go && sel == REG_TXD),
        .ctrl_wr      (wr_go && sel == REG_CTRL),
        .ctrl_new_txen(req_wdata[CTRL_TXEN_BIT]),
        .txen         (ctrl_q[CTRL_TXEN_BIT]),
        .evt_break    (evt_break),
        .evt_rx_full  (evt_rx_full),
        .evt_rx_ready (evt_rx_ready),
        .flags        (flags)
    );

    sercsr_regs #(
        .FIFO_VARIANT(FIFO_VARIANT),
        .DATA_W      (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_go),
        .sel     (sel),
        .wdata   (req_wdata),
        .mode_q  (mode_q),
        .rate_q  (rate_q),
        .ctrl_q  (ctrl_q),
        .txd_q   (txd_q),
        .fctl_q  (fctl_q),
        .port_q  (port_q),
        .tx_valid(tx_valid)
    );

    assign tx_data = txd_q;

    // R6: status word layout
    always_comb begin
        stat_word                = '0;
        stat_word[STAT_TEND_BIT] = flags.tend;
        stat_word[STAT_TDE_BIT]  = flags.tde;
        stat_word[STAT_BRK_BIT]  = flags.brk;
        stat_word[STAT_RXF_BIT]  = flags.rxf;
        stat_word[STAT_RDY_BIT]  = flags.rdy;
    end

    always_comb begin
        case (sel)
            REG_MODE:  rd_word = zext(mode_q);
            REG_RATE:  rd_word = zext(rate_q);
            REG_CTRL:  rd_word = zext(ctrl_q);
            REG_TXD:   rd_word = zext(txd_q);
            REG_STAT:  rd_word = stat_word;
            REG_FCTL:  rd_word = zext(fctl_q);
            REG_RXCNT: rd_word = {{(RDATA_W-CNT_W){1'b0}}, rx_count};   // R10
            REG_PORT:  rd_word = zext(port_q);
            default:   rd_word = '0;                                    // R11
        endcase
    end

    // next-state choice from the request just presented
    always_comb begin
        if (!req_valid)  state_d = ST_IDLE;
        else if (hit)    state_d = ST_ACK;
        else             state_d = ST_FAULT;
    end

    always_comb begin
        if (!req_valid || !hit) rdata_d = '1;
        else if (req_write)     rdata_d = '0;
        else                    rdata_d = rd_word;
    end

    // state register (plus the response data it qualifies)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rsp_rdata <= '1;
        end else begin
            state_q   <= state_d;
            rsp_rdata <= rdata_d;
        end
    end

    // outputs from the state
    always_comb begin
        unique case (state_q)
            ST_ACK: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b0;
            end
            ST_FAULT: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_err   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sercsr_front_chk.sv
module sercsr_front_chk #(
    parameter bit FIFO_VARIANT = 1'b1,
    parameter int ADDR_W       = 6,
    parameter int RDATA_W      = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic [RDATA_W-1:0] rsp_rdata,
    input logic               tx_valid
);

    localparam logic [ADDR_W-1:0] STAT_OFFS = ADDR_W'(16);
    localparam logic [ADDR_W-1:0] LINE_OFFS = ADDR_W'(36);

    logic stat_read, line_read;
    assign stat_read = req_valid && !req_write && req_addr == STAT_OFFS;
    assign line_read = req_valid && !req_write && req_addr == LINE_OFFS;

    a_r1_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r1_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_err || rsp_rdata == '0));

    a_r2_err_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> rsp_rdata == '1);

    a_r2_err_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !tx_valid);

    a_r5_tx_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> !tx_valid);

    a_r6_stat_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (FIFO_VARIANT && stat_read) |=> (rsp_rdata[RDATA_W-1:7] == '0 && rsp_rdata[3:2] == 2'b00));

    a_r11_line_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (FIFO_VARIANT && line_read) |=> rsp_rdata == '0);

endmodule

bind sercsr_front sercsr_front_chk #(
    .FIFO_VARIANT(FIFO_VARIANT),
    .ADDR_W      (ADDR_W),
    .RDATA_W     (RDATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .rsp_rdata(rsp_rdata),
    .tx_valid (tx_valid)
);

// File: tb/test_sercsr_front.sv
module test_sercsr_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    // FIFO-variant instance signals
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [4:0]  rx_count = 5'd9;
    logic        evt_break = 1'b0, evt_rx_full = 1'b0, evt_rx_ready = 1'b0;
    logic        rsp_valid, rsp_err, tx_valid;
    logic [15:0] rsp_rdata;
    logic [7:0]  tx_data;

    // plain-variant instance signals
    logic        p_req_valid = 1'b0, p_req_write = 1'b0;
    logic [5:0]  p_req_addr = '0;
    logic [7:0]  p_req_wdata = '0;
    logic        p_rsp_valid, p_rsp_err, p_tx_valid;
    logic [15:0] p_rsp_rdata;
    logic [7:0]  p_tx_data;

    sercsr_front i_sercsr_front (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rx_count(rx_count), .evt_break(evt_break), .evt_rx_full(evt_rx_full), .evt_rx_ready(evt_rx_ready),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data)
    );

    sercsr_front #(.FIFO_VARIANT(1'b0)) i_sercsr_front_plain (
        .clk(clk), .rst_n(rst_n),
        .req_valid(p_req_valid), .req_write(p_req_write), .req_addr(p_req_addr), .req_wdata(p_req_wdata),
        .rx_count(5'd0), .evt_break(1'b0), .evt_rx_full(1'b0), .evt_rx_ready(1'b0),
        .rsp_valid(p_rsp_valid), .rsp_err(p_rsp_err), .rsp_rdata(p_rsp_rdata),
        .tx_valid(p_tx_valid), .tx_data(p_tx_data)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic        g_valid, g_err, g_tx;
    logic [15:0] g_rdata;
    logic [7:0]  g_txd;

    task automatic check(input int req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // starts and ends on a falling edge
    task automatic acc(input logic wr, input logic [5:0] a, input logic [7:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        g_valid = rsp_valid; g_err = rsp_err; g_rdata = rsp_rdata; g_tx = tx_valid; g_txd = tx_data;
        req_valid = 1'b0;
    endtask

    task automatic p_acc(input logic wr, input logic [5:0] a, input logic [7:0] d);
        p_req_valid = 1'b1; p_req_write = wr; p_req_addr = a; p_req_wdata = d;
        @(negedge clk);
        g_valid = p_rsp_valid; g_err = p_rsp_err; g_rdata = p_rsp_rdata; g_tx = p_tx_valid; g_txd = p_tx_data;
        p_req_valid = 1'b0;
    endtask

    // {write, offset, wdata, exp_err, exp_rdata, requirement}
    localparam int NVEC = 33;
    localparam logic [35:0] VEC [NVEC] = '{
        {1'b0, 6'h04, 8'h00, 1'b0, 16'h00FF, 4'd9},   // R9 bit rate reset
        {1'b0, 6'h00, 8'h00, 1'b0, 16'h0000, 4'd9},   // R9 mode reset
        {1'b0, 6'h10, 8'h00, 1'b0, 16'h0060, 4'd6},   // R6 / R9 flags reset
        {1'b1, 6'h00, 8'hFF, 1'b0, 16'h0000, 4'd3},
        {1'b0, 6'h00, 8'h00, 1'b0, 16'h007B, 4'd3},   // R3 mode mask
        {1'b1, 6'h08, 8'hFF, 1'b0, 16'h0000, 4'd3},
        {1'b0, 6'h08, 8'h00, 1'b0, 16'h00FB, 4'd3},   // R3 control mask
        {1'b1, 6'h0C, 8'hA5, 1'b0, 16'h0000, 4'd5},   // R5 transmit
        {1'b0, 6'h10, 8'h00, 1'b0, 16'h0040, 4'd8},   // R8 pre-read value
        {1'b0, 6'h10, 8'h00, 1'b0, 16'h0060, 4'd8},   // R8 re-armed
        {1'b1, 6'h10, 8'h20, 1'b0, 16'h0000, 4'd7},
        {1'b0, 6'h10, 8'h00, 1'b0, 16'h0020, 4'd7},   // R7 selective clear
        {1'b0, 6'h10, 8'h00, 1'b0, 16'h0060, 4'd8},
        {1'b1, 6'h08, 8'h00, 1'b0, 16'h0000, 4'd4},
        {1'b1, 6'h10, 8'h00, 1'b0, 16'h0000, 4'd7},
        {1'b0, 6'h10, 8'h00, 1'b0, 16'h0000, 4'd7},   // R7 all cleared
        {1'b0, 6'h10, 8'h00, 1'b0, 16'h0000, 4'd8},   // R8 no re-arm when disabled
        {1'b1, 6'h08, 8'h00, 1'b0, 16'h0000, 4'd4},
        {1'b0, 6'h10, 8'h00, 1'b0, 16'h0040, 4'd4},   // R4 transmit end set
        {1'b1, 6'h18, 8'h3C, 1'b0, 16'h0000, 4'd13},
        {1'b0, 6'h18, 8'h00, 1'b0, 16'h003C, 4'd13},  // R13
        {1'b1, 6'h20, 8'h81, 1'b0, 16'h0000, 4'd13},
        {1'b0, 6'h20, 8'h00, 1'b0, 16'h0081, 4'd13},  // R13
        {1'b1, 6'h24, 8'hFF, 1'b0, 16'h0000, 4'd11},
        {1'b0, 6'h24, 8'h00, 1'b0, 16'h0000, 4'd11},  // R11
        {1'b0, 6'h1C, 8'h00, 1'b0, 16'h0009, 4'd10},  // R10
        {1'b0, 6'h14, 8'h00, 1'b1, 16'hFFFF, 4'd2},   // R2 gap
        {1'b1, 6'h14, 8'h00, 1'b1, 16'hFFFF, 4'd2},
        {1'b0, 6'h0C, 8'h00, 1'b1, 16'hFFFF, 4'd2},   // R2 write-only here
        {1'b0, 6'h02, 8'h00, 1'b1, 16'hFFFF, 4'd2},   // R2 unaligned
        {1'b0, 6'h28, 8'h00, 1'b1, 16'hFFFF, 4'd2},   // R2 past window
        {1'b0, 6'h3C, 8'h00, 1'b1, 16'hFFFF, 4'd2},
        {1'b1, 6'h1C, 8'h55, 1'b1, 16'hFFFF, 4'd2}    // R2 read-only offset
    };

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R1 watchdog: actual %h expected %h", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, "idle rsp_valid after reset", rsp_valid, 0);   // R1
        check(9, "tx_valid after reset", tx_valid, 0);          // R9

        for (int i = 0; i < NVEC; i++) begin
            acc(VEC[i][35], VEC[i][34:29], VEC[i][28:21]);
            check(1, $sformatf("vec %0d rsp_valid", i), g_valid, 1);
            check(int'(VEC[i][3:0]), $sformatf("vec %0d rsp_err", i), g_err, VEC[i][20]);
            check(int'(VEC[i][3:0]), $sformatf("vec %0d rdata", i), g_rdata, VEC[i][19:4]);
            check(5, $sformatf("vec %0d tx_valid", i), g_tx,
                  VEC[i][35] && VEC[i][34:29] == 6'h0C && !VEC[i][20]);
            if (g_tx) check(5, "tx_data", g_txd, VEC[i][28:21]);
        end

        @(negedge clk);
        check(1, "no request no response", rsp_valid, 0);        // R1

        // R2: rejected access leaves the mode register alone
        acc(1'b1, 6'h01, 8'h00);
        check(2, "unaligned write err", g_err, 1);
        acc(1'b0, 6'h00, 8'h00);
        check(2, "mode after rejected write", g_rdata, 16'h007B);

        // R12: event inputs set flags (transmit end 1, data empty 0 here)
        evt_break = 1'b1; evt_rx_full = 1'b1; evt_rx_ready = 1'b1;
        @(negedge clk);
        evt_break = 1'b0; evt_rx_full = 1'b0; evt_rx_ready = 1'b0;
        acc(1'b0, 6'h10, 8'h00);
        check(12, "events set flags", g_rdata, 16'h0053);
        evt_break = 1'b1;
        acc(1'b1, 6'h10, 8'h00);
        evt_break = 1'b0;
        acc(1'b0, 6'h10, 8'h00);
        check(12, "set wins over clear", g_rdata, 16'h0010);

        // plain variant
        p_acc(1'b0, 6'h0C, 8'h00);
        check(9, "plain data reset", g_rdata, 16'h00FF);
        p_acc(1'b1, 6'h00, 8'hFF);
        p_acc(1'b0, 6'h00, 8'h00);
        check(3, "plain mode unmasked", g_rdata, 16'h00FF);
        p_acc(1'b1, 6'h08, 8'hFF);
        p_acc(1'b0, 6'h08, 8'h00);
        check(3, "plain control unmasked", g_rdata, 16'h00FF);
        p_acc(1'b0, 6'h10, 8'h00);
        check(2, "plain status err", g_err, 1);
        check(2, "plain status rdata", g_rdata, 16'hFFFF);
        p_acc(1'b1, 6'h0C, 8'h3C);
        check(5, "plain tx_valid", g_tx, 1);
        check(5, "plain tx_data", g_txd, 8'h3C);
        p_acc(1'b0, 6'h0C, 8'h00);
        check(5, "plain data readback", g_rdata, 16'h003C);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule